// File: doc/BRIEF.md
# Ten-to-Two Serializer Gearbox

This block turns a stream of 10-bit line characters into a stream of 2-bit symbol pairs, one pair per cycle of the internal serial clock. A DDR output stage downstream sends the lower bit of each pair on the rising edge and the upper bit on the falling edge. At full rate a fresh character is taken every five cycles. The character source sees a one-cycle load strobe and must present its character, with a valid flag, in that same cycle.

When the source has no valid character at a load point, the gearbox inserts the K28.5 comma. Its polarity is picked by a running-disparity hint that the upstream encoder provides. The serial clock can also be left at its full frequency while the link runs at half the baud rate. In that case a rate select makes every pair last two cycles, and a character is taken every ten cycles. Reset preloads the shift register with the negative-disparity K28.5, so the link carries a defined idle pattern from the first cycle.

Top module: `ser10to2_gearbox`

## Requirements
- R1: During reset and in the first cycle after it, `sym_out` shows the first pair of K28.5 negative disparity (value 10'h17C, so pair 2'b00) and `load_strobe` is low. The five pairs of that character are then sent before the first load.
- R2: With `rate_half` low, `load_strobe` is high for one cycle in every five. The first strobe falls in cycle 4 after reset, counting the first cycle after reset as cycle 0.
- R3: A character taken at a strobe with `char_valid` high appears in the next five cycles as pairs {c[1],c[0]}, {c[3],c[2]} … {c[9],c[8]}. Bit 0 (the first bit on the line) is on `sym_out[0]`, the rising-edge lane.
- R4: If `char_valid` is low at a strobe, K28.5 is sent instead: 10'h17C when `idle_rd_pos` is 0 and 10'h283 when it is 1. The pair order is the same as in R3.
- R5: With `rate_half` high, every pair is held for two cycles. `load_strobe` rises in the second cycle of the last pair, once every ten cycles, first in cycle 9 after reset.
- R6: `char_in`, `char_valid` and `idle_rd_pos` have no effect on the output in cycles where `load_strobe` is low.
- R7: A reset asserted in the middle of a character abandons it and restarts the sequence of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_half | input | 1 | 1: each pair held two cycles (half baud rate); change only during reset |
| char_in | input | 10 | Character to serialize, bit 0 sent first |
| char_valid | input | 1 | `char_in` is valid in a strobe cycle |
| idle_rd_pos | input | 1 | Disparity for an inserted K28.5: 0 negative, 1 positive |
| sym_out | output | 2 | Pair for the DDR stage: [0] rising edge, [1] falling edge |
| load_strobe | output | 1 | Character is taken at the end of this cycle |

## Verification
The hardest case to reach from the ports is an inserted comma that lands directly between two data characters, with either disparity. Another is a burst of stray inputs in the four (or nine) cycles between strobes, and the gearbox must ignore it. The bench sweeps all 1024 character codes at full rate and drops the valid flag at a fixed period. It toggles the disparity hint with the sweep index, so both comma polarities follow arbitrary data. In every non-strobe cycle it drives the complement of the pending character and an inverted valid flag. A half-rate sweep and a reset in the middle of a character complete the stimulus.

// File: rtl/ser_gbx_pkg.sv
// Package: shared constants and the idle-character helper for the gearbox.
// Assumes 10-bit line characters with bit 0 the first bit on the line.
package ser_gbx_pkg;

    localparam int CHAR_W = 10;

    // Comma character in both disparities, bit 0 = first transmitted bit.
    localparam logic [CHAR_W-1:0] K285_NEG = 10'h17C;
    localparam logic [CHAR_W-1:0] K285_POS = 10'h283;

    // Picks the comma polarity from the upstream disparity hint.
    function automatic logic [CHAR_W-1:0] idle_char(input logic rd_pos);
        return rd_pos ? K285_POS : K285_NEG;
    endfunction

endpackage

// File: rtl/ser_gbx_pace.sv
// Module: pair pacing. Counts pairs within a character and, at half rate,
// holds each pair for two cycles. Emits the advance enable and load pulse.
// Assumes rate_half is static outside reset.
module ser_gbx_pace #(
    parameter int PAIRS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rate_half,
    output logic advance,
    output logic load_now
);
    localparam int CNT_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PAIRS - 1);

    logic [CNT_W-1:0] pair_cnt;
    logic             hold_q;

    // Move to the next pair every cycle, or every second cycle at half rate.
    always_comb begin
        advance  = !rate_half || hold_q;
        load_now = advance && (pair_cnt == LAST);
    end

    // Track the pair index and the half-rate hold phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_cnt <= '0;
            hold_q   <= 1'b0;
        end else begin
            hold_q <= rate_half && !hold_q;
            if (advance) begin
                pair_cnt <= (pair_cnt == LAST) ? '0 : pair_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ser_gbx_fill.sv
// Module: next-character selection. Passes the source character when valid,
// else the comma in the disparity requested upstream. Purely combinational.
module ser_gbx_fill
    import ser_gbx_pkg::*;
(
    input  logic [CHAR_W-1:0] char_in,
    input  logic              char_valid,
    input  logic              idle_rd_pos,
    output logic [CHAR_W-1:0] next_char
);
    // Substitute the comma when the source has nothing ready.
    always_comb begin
        next_char = char_valid ? char_in : idle_char(idle_rd_pos);
    end
endmodule

// File: rtl/ser_gbx_shift.sv
// Module: character shift register. Loads a whole character on load_now,
// otherwise shifts LANE_W bits toward the output on each advance.
// Reset value is the negative-disparity comma so the line idles cleanly.
module ser_gbx_shift
    import ser_gbx_pkg::*;
#(
    parameter int LANE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              load_now,
    input  logic [CHAR_W-1:0] next_char,
    output logic [LANE_W-1:0] lane_out
);
    logic [CHAR_W-1:0] shreg;

    // Hold, shift or reload the character being sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= K285_NEG;
        end else if (load_now) begin
            shreg <= next_char;
        end else if (advance) begin
            shreg <= {{LANE_W{1'b0}}, shreg[CHAR_W-1:LANE_W]};
        end
    end

    // The low lanes of the register are the pair on the line.
    always_comb begin
        lane_out = shreg[LANE_W-1:0];
    end
endmodule

// File: rtl/ser10to2_gearbox.sv
// Module: ten-to-two serializer gearbox top. Wires pacing, fill selection
// and the shift register. Assumes the source answers load_strobe in the
// same cycle and that rate_half changes only during reset.
module ser10to2_gearbox
    import ser_gbx_pkg::*;
#(
    parameter int LANE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_half,
    input  logic [CHAR_W-1:0] char_in,
    input  logic              char_valid,
    input  logic              idle_rd_pos,
    output logic [LANE_W-1:0] sym_out,
    output logic              load_strobe
);
    localparam int PAIRS = CHAR_W / LANE_W;

    logic              advance;
    logic              load_now;
    logic [CHAR_W-1:0] next_char;

    ser_gbx_pace #(.PAIRS(PAIRS)) u_pace (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_half (rate_half),
        .advance   (advance),
        .load_now  (load_now)
    );

    ser_gbx_fill u_fill (
        .char_in     (char_in),
        .char_valid  (char_valid),
        .idle_rd_pos (idle_rd_pos),
        .next_char   (next_char)
    );

    ser_gbx_shift #(.LANE_W(LANE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .load_now  (load_now),
        .next_char (next_char),
        .lane_out  (sym_out)
    );

    // The load pulse to the source is the pacing load point.
    always_comb begin
        load_strobe = load_now;
    end
endmodule

// File: rtl/ser10to2_gearbox_chk.sv
// Checker: port-level properties of the gearbox, bound to the top module.
module ser10to2_gearbox_chk #(
    parameter int LANE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rate_half,
    input logic [9:0]        char_in,
    input logic              char_valid,
    input logic              idle_rd_pos,
    input logic [LANE_W-1:0] sym_out,
    input logic              load_strobe
);
    localparam int PAIRS = 10 / LANE_W;
    localparam logic [7:0] FULL_GAP = 8'(PAIRS - 1);
    localparam logic [7:0] HALF_GAP = 8'(2 * PAIRS - 1);

    logic [7:0]        gap;
    logic              odd;
    logic [LANE_W-1:0] idle_lo;

    // Cycles since reset or the last strobe, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap <= '0;
            odd <= 1'b0;
        end else begin
            odd <= !odd;
            if (load_strobe)      gap <= '0;
            else if (gap != 8'hFF) gap <= gap + 8'd1;
        end
    end

    // First pair of the comma expected for the current hint.
    always_comb begin
        idle_lo = idle_rd_pos ? {LANE_W{1'b1}} : {LANE_W{1'b0}};
    end

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (sym_out == '0 && !load_strobe));
    a_r2_full_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (!rate_half && load_strobe) |-> gap == FULL_GAP);
    a_r2_full_no_early: assert property (@(posedge clk) disable iff (!rst_n)
        (!rate_half && gap != FULL_GAP) |-> !load_strobe);
    a_r3_first_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (load_strobe && char_valid) |=> sym_out == $past(char_in[LANE_W-1:0]));
    a_r4_idle_first: assert property (@(posedge clk) disable iff (!rst_n)
        (load_strobe && !char_valid) |=> sym_out == $past(idle_lo));
    a_r5_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_half && odd) |-> $stable(sym_out));
    a_r5_half_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_half && load_strobe) |-> gap == HALF_GAP);
endmodule

bind ser10to2_gearbox ser10to2_gearbox_chk #(.LANE_W(LANE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rate_half   (rate_half),
    .char_in     (char_in),
    .char_valid  (char_valid),
    .idle_rd_pos (idle_rd_pos),
    .sym_out     (sym_out),
    .load_strobe (load_strobe)
);

// File: tb/ser10to2_gearbox_bench.sv
`timescale 1ns/1ps
module ser10to2_gearbox_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rate_half = 1'b0;
    logic [9:0] char_in = '0;
    logic       char_valid = 1'b0;
    logic       idle_rd_pos = 1'b0;
    logic [1:0] sym_out;
    logic       load_strobe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Bench model state: the character on the line, pair index, hold phase.
    logic [9:0] m_cur;
    int         m_p;
    bit         m_h;
    bit         m_idle;
    bit         m_first;

    ser10to2_gearbox u_ser10to2_gearbox (
        .clk(clk), .rst_n(rst_n), .rate_half(rate_half), .char_in(char_in),
        .char_valid(char_valid), .idle_rd_pos(idle_rd_pos),
        .sym_out(sym_out), .load_strobe(load_strobe)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Synchronous reset; ends at a negedge with model at cycle 0 (R1, R7).
    task automatic do_reset(input bit half);
        @(negedge clk);
        rst_n = 1'b0;
        rate_half = half;
        repeat (3) @(negedge clk);
        chk(sym_out == 2'b00, "R1 reset pair", sym_out, 0);
        chk(load_strobe == 1'b0, "R1 reset strobe", load_strobe, 0);
        rst_n = 1'b1;
        m_cur = 10'h17C; m_p = 0; m_h = 0; m_idle = 1; m_first = 1;
    endtask

    // One cycle at a negedge: check outputs, drive inputs, update model.
    task automatic tick(input bit half, input logic [9:0] nc, input bit nv,
                        input bit nr, output bit took);
        logic [1:0] e_sym;
        bit         e_ld;
        bit         adv;
        string      tag;
        e_sym = m_cur[2*m_p +: 2];
        e_ld  = (m_p == 4) && (!half || m_h);
        tag = m_first ? "R1" : (m_idle ? "R4/R6" : (half ? "R5/R6" : "R3/R6"));
        chk(sym_out == e_sym, tag, sym_out, e_sym);
        chk(load_strobe == e_ld, half ? "R5 strobe" : "R2 strobe", load_strobe, e_ld);
        if (e_ld) begin
            char_in = nc; char_valid = nv; idle_rd_pos = nr; took = 1;
        end else begin
            char_in = ~nc; char_valid = ~nv; idle_rd_pos = ~nr; took = 0;
        end
        adv = !half || m_h;
        m_h = half ? !m_h : 1'b0;
        if (adv) begin
            if (m_p == 4) begin
                m_cur = nv ? nc : (nr ? 10'h283 : 10'h17C);
                m_idle = !nv; m_first = 0; m_p = 0;
            end else begin
                m_p++;
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #1_500_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        bit took;
        // Full-rate sweep of every character code (R2, R3, R4, R6).
        do_reset(1'b0);
        for (int n = 0; n < 1024; ) begin
            tick(1'b0, 10'(n), (n % 7) != 3, n[0] ^ n[3], took);
            if (took) n++;
        end
        // Reset partway into a character (R7), then resume.
        for (int i = 0; i < 7; i++) tick(1'b0, 10'h155, 1'b1, 1'b0, took);
        do_reset(1'b0);
        for (int i = 0; i < 12; i++) tick(1'b0, 10'h2AA, 1'b1, 1'b1, took);
        // Half-rate sweep (R5) with idles mixed in (R4).
        do_reset(1'b1);
        for (int n = 0; n < 120; ) begin
            tick(1'b1, 10'((n * 37 + 5) % 1024), (n % 5) != 2, n[1], took);
            if (took) n++;
        end
        finish_run();
    end
endmodule